// File: doc/BRIEF.md
# DMA Channel Address/Count Sequencer

This block is the per-channel transfer engine of a four-channel third-party DMA controller. Each channel holds programmed base values (start address, count, page byte and mode) and a pair of working registers (current address, current count). Starting a transaction copies the base values into the working registers. After that, every transfer beat the arbiter grants to the channel moves the address up or down by one and lowers the count by one. The programmed count is the length minus one, so the beat taken at count zero is the last one.

At terminal count the channel pulses a done flag for one cycle and sets a sticky status bit. With automatic re-initialisation it spends one cycle reloading its working registers and keeps running. Without it, it masks itself and returns to idle. A channel in cascade mode does no sequencing and only forwards request and acknowledge. The address presented for the granted channel is the page byte above the 16-bit current address, together with a direction flag.

Each channel is a four-state machine. IDLE goes to RUN on an accepted start and to CASCADE on a cascade mode write. RUN goes to RELOAD on terminal count with auto-init, to IDLE on terminal count without it, and to CASCADE on a cascade mode write. RELOAD always goes to RUN after one cycle, unless a cascade mode write arrives, which sends it to CASCADE. CASCADE goes to IDLE on any non-cascade mode write.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset every channel is masked (mask_o = 4'hF), idle, has tc_stat_o and done_o clear, and accepts no beat.
- R2: A mode write (wr_sel = 3) applies to the channel in wr_data[1:0], whatever wr_chan holds. Mode bits [3:2] = 01 mean device-to-memory and give dir_o = 1. Bits [3:2] = 10 mean memory-to-device and give dir_o = 0. Bit 4 enables auto-init, bit 5 selects decrement, and bits [7:6] = 11 select cascade.
- R3: A start (start_i, start_chan) is accepted only by an idle, unmasked channel. It loads the current address and current count from the base registers, and the channel accepts beats from the next cycle.
- R4: While beat_chan selects a channel, mem_addr_o is {page, current address}. Each accepted beat moves the 16-bit address by +1, or by -1 when mode bit 5 is set. The address wraps within 16 bits and never carries into the page.
- R5: Each accepted beat lowers the current count by one, shown on cnt_o, so a programmed count of N-1 gives exactly N accepted beats before terminal count.
- R6: A beat accepted at count 0 is terminal count. The count wraps to 16'hFFFF, tc_stat_o of that channel sets, and done_o pulses for exactly one cycle, one cycle after that beat.
- R7: Without auto-init, terminal count sets the channel's mask bit and returns it to idle. Later beats are ignored and the count stays unchanged.
- R8: With auto-init, the cycle after terminal count ignores beats and reloads the working registers from the base registers as they stand then, including values written during the run. The channel then accepts beats again and stays unmasked.
- R9: A masked, idle or reloading channel raises no beat_ok_o, and a start to a masked channel is ignored.
- R10: A channel in cascade mode ignores start and beat, drives casc_req_o from dreq_i and drives casc_ack_o from ack_i. Every other channel drives zero on both.
- R11: A mask write (wr_sel = 4) sets the mask of channel wr_data[1:0] when wr_data[2] = 1 and clears it when wr_data[2] = 0. Base address, base count and page writes (wr_sel = 0, 1, 2) go to channel wr_chan.
- R12: An accepted start clears that channel's tc_stat_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select: 0 base address, 1 base count, 2 page, 3 mode, 4 mask |
| wr_chan | input | 2 | Target channel for base address, base count and page writes |
| wr_data | input | 16 | Write data |
| start_i | input | 1 | Start a transaction |
| start_chan | input | 2 | Channel to start |
| beat_i | input | 1 | A transfer beat is granted this cycle |
| beat_chan | input | 2 | Channel granted the beat; also selects the address output |
| dreq_i | input | 4 | Downstream requests for cascaded channels |
| ack_i | input | 4 | Upstream acknowledges for cascaded channels |
| mem_addr_o | output | 24 | {page, current address} of the selected channel |
| dir_o | output | 1 | 1 = device-to-memory for the selected channel |
| cnt_o | output | 16 | Current count of the selected channel |
| beat_ok_o | output | 1 | The granted beat is accepted |
| done_o | output | 4 | One-cycle terminal-count pulse per channel |
| tc_stat_o | output | 4 | Sticky terminal-count status per channel |
| mask_o | output | 4 | Per-channel mask |
| casc_req_o | output | 4 | Forwarded requests of cascaded channels |
| casc_ack_o | output | 4 | Forwarded acknowledges of cascaded channels |

## Verification
The step properties assume that beat_chan names at most one channel per cycle. They also assume that, when beat_chan stays the same across two cycles, nothing but the beat changes that channel's working registers. If beat_chan changes between cycles, the address and count step checks become vacuous. The stimulus meets these assumptions: it drives inputs only at the falling edge, grants beats to one channel held steady for a whole transaction, and makes register writes only in cycles without a beat on the written channel. The sweep runs every count from 0 to 5 in both directions on one channel. Separate runs cover address wrap at both ends, auto-init reload with a base rewritten mid-run, masking, and cascade forwarding.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [1:0] {
        CH_IDLE    = 2'd0,
        CH_RUN     = 2'd1,
        CH_RELOAD  = 2'd2,
        CH_CASCADE = 2'd3
    } ch_state_t;

    localparam logic [2:0] SEL_BASE_ADDR = 3'd0;
    localparam logic [2:0] SEL_BASE_CNT  = 3'd1;
    localparam logic [2:0] SEL_PAGE      = 3'd2;
    localparam logic [2:0] SEL_MODE      = 3'd3;
    localparam logic [2:0] SEL_MASK      = 3'd4;

    localparam int MB_TO_MEM   = 2;
    localparam int MB_AUTO     = 4;
    localparam int MB_DECR     = 5;
    localparam int MB_XFER_LO  = 6;
    localparam int MB_MASK_SET = 2;

    typedef struct packed {
        logic decr;
        logic autoi;
        logic to_mem;
    } chan_mode_t;

endpackage

// File: rtl/dma_wr_decode.sv
module dma_wr_decode
    import dma_seq_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 16,
    localparam int CW = $clog2(NCH)
) (
    input  logic           wr_en,
    input  logic [2:0]     wr_sel,
    input  logic [CW-1:0]  wr_chan,
    input  logic [DW-1:0]  wr_data,
    output logic [NCH-1:0] st_addr,
    output logic [NCH-1:0] st_cnt,
    output logic [NCH-1:0] st_page,
    output logic [NCH-1:0] st_mode,
    output logic [NCH-1:0] st_mask
);

    for (genvar i = 0; i < NCH; i++) begin : g_dec
        // base, count and page follow wr_chan; mode and mask carry the channel in the data
        assign st_addr[i] = wr_en && (wr_sel == SEL_BASE_ADDR) && (wr_chan == CW'(i));
        assign st_cnt[i]  = wr_en && (wr_sel == SEL_BASE_CNT)  && (wr_chan == CW'(i));
        assign st_page[i] = wr_en && (wr_sel == SEL_PAGE)      && (wr_chan == CW'(i));
        assign st_mode[i] = wr_en && (wr_sel == SEL_MODE)      && (wr_data[CW-1:0] == CW'(i));
        assign st_mask[i] = wr_en && (wr_sel == SEL_MASK)      && (wr_data[CW-1:0] == CW'(i));
    end

endmodule

// File: rtl/dma_chan_unit.sv
module dma_chan_unit
    import dma_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int PW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_addr,
    input  logic          st_cnt,
    input  logic          st_page,
    input  logic          st_mode,
    input  logic          st_mask,
    input  logic [DW-1:0] wr_data,
    input  logic          start,
    input  logic          beat,
    output logic [AW-1:0] cur_addr,
    output logic [AW-1:0] cur_cnt,
    output logic [PW-1:0] page,
    output logic          to_mem,
    output logic          cascade,
    output logic          mask,
    output logic          tc_stat,
    output logic          done,
    output logic          accept
);

    ch_state_t  state, nxt;
    chan_mode_t mode_q;
    logic [AW-1:0] base_addr, base_cnt;
    logic casc_wr, norm_wr, start_ok, at_tc;

    assign casc_wr  = st_mode && (wr_data[MB_XFER_LO+1:MB_XFER_LO] == 2'b11);
    assign norm_wr  = st_mode && !casc_wr;
    assign accept   = beat && (state == CH_RUN) && !mask;
    assign start_ok = start && (state == CH_IDLE) && !mask && !casc_wr;
    assign at_tc    = accept && (cur_cnt == '0);
    assign to_mem   = mode_q.to_mem;
    assign cascade  = (state == CH_CASCADE);

    // next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            CH_IDLE: begin
                if (casc_wr)       nxt = CH_CASCADE;
                else if (start_ok) nxt = CH_RUN;
            end
            CH_RUN: begin
                if (casc_wr)       nxt = CH_CASCADE;
                else if (at_tc)    nxt = mode_q.autoi ? CH_RELOAD : CH_IDLE;
            end
            CH_RELOAD: begin
                if (casc_wr)       nxt = CH_CASCADE;
                else               nxt = CH_RUN;
            end
            CH_CASCADE: begin
                if (norm_wr)       nxt = CH_IDLE;
            end
            default:               nxt = CH_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= CH_IDLE;
        else        state <= nxt;
    end

    // registers and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr <= '0;
            base_cnt  <= '0;
            page      <= '0;
            mode_q    <= '0;
            cur_addr  <= '0;
            cur_cnt   <= '0;
            mask      <= 1'b1;
            tc_stat   <= 1'b0;
            done      <= 1'b0;
        end else begin
            if (st_addr) base_addr <= wr_data[AW-1:0];
            if (st_cnt)  base_cnt  <= wr_data[AW-1:0];
            if (st_page) page      <= wr_data[PW-1:0];
            if (st_mode) begin
                mode_q.decr   <= wr_data[MB_DECR];
                mode_q.autoi  <= wr_data[MB_AUTO];
                mode_q.to_mem <= wr_data[MB_TO_MEM];
            end

            if (start_ok || (state == CH_RELOAD)) begin
                cur_addr <= base_addr;
                cur_cnt  <= base_cnt;
            end else if (accept) begin
                cur_addr <= mode_q.decr ? cur_addr - 1'b1 : cur_addr + 1'b1;
                cur_cnt  <= cur_cnt - 1'b1;
            end

            if (st_mask)                    mask <= wr_data[MB_MASK_SET];
            else if (at_tc && !mode_q.autoi) mask <= 1'b1;

            if (start_ok)   tc_stat <= 1'b0;
            else if (at_tc) tc_stat <= 1'b1;

            done <= at_tc;
        end
    end

endmodule

// File: rtl/dma_beat_mux.sv
module dma_beat_mux #(
    parameter int NCH = 4,
    parameter int AW  = 16,
    parameter int PW  = 8,
    localparam int CW = $clog2(NCH)
) (
    input  logic [CW-1:0]          sel,
    input  logic [NCH-1:0][AW-1:0] addr_v,
    input  logic [NCH-1:0][AW-1:0] cnt_v,
    input  logic [NCH-1:0][PW-1:0] page_v,
    input  logic [NCH-1:0]         to_mem_v,
    input  logic [NCH-1:0]         accept_v,
    output logic [PW+AW-1:0]       mem_addr,
    output logic                   dir,
    output logic [AW-1:0]          cnt,
    output logic                   beat_ok
);

    assign mem_addr = {page_v[sel], addr_v[sel]};
    assign dir      = to_mem_v[sel];
    assign cnt      = cnt_v[sel];
    assign beat_ok  = |accept_v;

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
    import dma_seq_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 16,
    parameter int PW  = 8,
    parameter int DW  = 16,
    localparam int CW = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [CW-1:0]     wr_chan,
    input  logic [DW-1:0]     wr_data,
    input  logic              start_i,
    input  logic [CW-1:0]     start_chan,
    input  logic              beat_i,
    input  logic [CW-1:0]     beat_chan,
    input  logic [NCH-1:0]    dreq_i,
    input  logic [NCH-1:0]    ack_i,
    output logic [PW+AW-1:0]  mem_addr_o,
    output logic              dir_o,
    output logic [AW-1:0]     cnt_o,
    output logic              beat_ok_o,
    output logic [NCH-1:0]    done_o,
    output logic [NCH-1:0]    tc_stat_o,
    output logic [NCH-1:0]    mask_o,
    output logic [NCH-1:0]    casc_req_o,
    output logic [NCH-1:0]    casc_ack_o
);

    logic [NCH-1:0] st_addr, st_cnt, st_page, st_mode, st_mask;
    logic [NCH-1:0] to_mem_v, casc_v, accept_v;
    logic [NCH-1:0][AW-1:0] addr_v, cnt_v;
    logic [NCH-1:0][PW-1:0] page_v;

    dma_wr_decode #(.NCH(NCH), .DW(DW)) u_dec (
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_chan(wr_chan), .wr_data(wr_data),
        .st_addr(st_addr), .st_cnt(st_cnt), .st_page(st_page),
        .st_mode(st_mode), .st_mask(st_mask)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        dma_chan_unit #(.AW(AW), .PW(PW), .DW(DW)) u_ch (
            .clk(clk), .rst_n(rst_n),
            .st_addr(st_addr[i]), .st_cnt(st_cnt[i]), .st_page(st_page[i]),
            .st_mode(st_mode[i]), .st_mask(st_mask[i]), .wr_data(wr_data),
            .start(start_i && (start_chan == CW'(i))),
            .beat(beat_i && (beat_chan == CW'(i))),
            .cur_addr(addr_v[i]), .cur_cnt(cnt_v[i]), .page(page_v[i]),
            .to_mem(to_mem_v[i]), .cascade(casc_v[i]), .mask(mask_o[i]),
            .tc_stat(tc_stat_o[i]), .done(done_o[i]), .accept(accept_v[i])
        );
    end

    dma_beat_mux #(.NCH(NCH), .AW(AW), .PW(PW)) u_mux (
        .sel(beat_chan), .addr_v(addr_v), .cnt_v(cnt_v), .page_v(page_v),
        .to_mem_v(to_mem_v), .accept_v(accept_v),
        .mem_addr(mem_addr_o), .dir(dir_o), .cnt(cnt_o), .beat_ok(beat_ok_o)
    );

    assign casc_req_o = dreq_i & casc_v;
    assign casc_ack_o = ack_i & casc_v;

endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk #(
    parameter int NCH = 4,
    parameter int AW  = 16,
    parameter int PW  = 8,
    localparam int CW = $clog2(NCH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CW-1:0]    beat_chan,
    input logic             beat_ok_o,
    input logic [AW-1:0]    cnt_o,
    input logic [PW+AW-1:0] mem_addr_o,
    input logic [NCH-1:0]   done_o,
    input logic [NCH-1:0]   tc_stat_o,
    input logic [NCH-1:0]   mask_o
);

    AST_DONE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done_o)); // R6

    AST_TC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_ok_o && cnt_o == '0) |=> (done_o != '0)); // R6

    AST_TC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_ok_o && cnt_o == '0) |=> tc_stat_o[$past(beat_chan)]); // R6

    AST_NO_EARLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_ok_o && cnt_o != '0) |=> (done_o == '0)); // R5

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_ok_o && cnt_o != '0) |=>
            (!$stable(beat_chan) || cnt_o == $past(cnt_o) - 1'b1)); // R5

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_ok_o && cnt_o != '0) |=>
            (!$stable(beat_chan)
             || mem_addr_o[AW-1:0] == $past(mem_addr_o[AW-1:0]) + 1'b1
             || mem_addr_o[AW-1:0] == $past(mem_addr_o[AW-1:0]) - 1'b1)); // R4

    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        beat_ok_o |-> !mask_o[beat_chan]); // R9

endmodule

bind dma_chan_seq dma_seq_chk #(.NCH(NCH), .AW(AW), .PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .beat_chan(beat_chan), .beat_ok_o(beat_ok_o),
    .cnt_o(cnt_o), .mem_addr_o(mem_addr_o), .done_o(done_o),
    .tc_stat_o(tc_stat_o), .mask_o(mask_o)
);

// File: tb/tb_dma_chan_seq.sv
`timescale 1ns/1ps
module tb_dma_chan_seq;
    import dma_seq_pkg::*;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 1'b0, start_i = 1'b0, beat_i = 1'b0;
    logic [2:0] wr_sel = '0;
    logic [1:0] wr_chan = '0, start_chan = '0, beat_chan = '0;
    logic [15:0] wr_data = '0;
    logic [3:0] dreq_i = '0, ack_i = '0;
    logic [23:0] mem_addr_o;
    logic dir_o, beat_ok_o;
    logic [15:0] cnt_o;
    logic [3:0] done_o, tc_stat_o, mask_o, casc_req_o, casc_ack_o;
    int n_chk = 0, n_err = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    dma_chan_seq dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_chan(wr_chan),
        .wr_data(wr_data), .start_i(start_i), .start_chan(start_chan), .beat_i(beat_i),
        .beat_chan(beat_chan), .dreq_i(dreq_i), .ack_i(ack_i), .mem_addr_o(mem_addr_o),
        .dir_o(dir_o), .cnt_o(cnt_o), .beat_ok_o(beat_ok_o), .done_o(done_o),
        .tc_stat_o(tc_stat_o), .mask_o(mask_o), .casc_req_o(casc_req_o),
        .casc_ack_o(casc_ack_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [1:0] ch, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_chan = ch; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_xfer(input int ch, input logic [15:0] base, input int cnt,
                            input logic [7:0] pg, input logic [7:0] mode);
        logic [15:0] exp_a, nb;
        bit autoi, dec;
        autoi = mode[4]; dec = mode[5]; nb = base + 16'h0100;
        wr(SEL_MODE, 2'd0, {8'h00, mode | 8'(ch)});   // R2 channel from data
        wr(SEL_BASE_ADDR, 2'(ch), base);
        wr(SEL_BASE_CNT, 2'(ch), 16'(cnt));
        wr(SEL_PAGE, 2'(ch), {8'h00, pg});
        wr(SEL_MASK, 2'd0, 16'(ch));                  // R11 clear mask
        @(negedge clk); start_i = 1'b1; start_chan = 2'(ch);
        @(negedge clk); start_i = 1'b0;
        #1 chk("R12 tc cleared by start", 32'(tc_stat_o[ch]), 32'd0);
        if (autoi) wr(SEL_BASE_ADDR, 2'(ch), nb);     // base rewritten mid-run
        @(negedge clk);
        for (int k = 0; k <= cnt; k++) begin
            beat_i = 1'b1; beat_chan = 2'(ch);
            #1;
            exp_a = dec ? base - 16'(k) : base + 16'(k);
            chk("R3 beat accepted", 32'(beat_ok_o), 32'd1);
            chk("R4 address", 32'(mem_addr_o), 32'({pg, exp_a}));
            chk("R5 count", 32'(cnt_o), 32'(16'(cnt - k)));
            chk("R2 direction", 32'(dir_o), 32'(mode[2]));
            chk("R5 no early done", 32'(done_o), 32'd0);
            @(negedge clk);
        end
        #1;
        chk("R6 done pulse", 32'(done_o), 32'(4'b0001 << ch));
        chk("R6 tc status", 32'(tc_stat_o[ch]), 32'd1);
        chk("R6 count wrap", 32'(cnt_o), 32'h0000FFFF);
        if (autoi) begin
            chk("R8 reload cycle ignores beat", 32'(beat_ok_o), 32'd0);
            @(negedge clk); #1;
            chk("R8 running again", 32'(beat_ok_o), 32'd1);
            chk("R8 reloaded address", 32'(mem_addr_o), 32'({pg, nb}));
            chk("R8 reloaded count", 32'(cnt_o), 32'(cnt));
            chk("R8 unmasked", 32'(mask_o[ch]), 32'd0);
            chk("R6 single pulse", 32'(done_o), 32'd0);
            @(negedge clk); beat_i = 1'b0;
            wr(SEL_MODE, 2'd0, {8'h00, 8'hC0 | 8'(ch)});  // park channel
        end else begin
            chk("R7 beat ignored", 32'(beat_ok_o), 32'd0);
            chk("R7 self mask", 32'(mask_o[ch]), 32'd1);
            @(negedge clk); beat_i = 1'b0;
            #1;
            chk("R6 single pulse", 32'(done_o), 32'd0);
            beat_chan = 2'(ch); #1;
            chk("R7 count unchanged", 32'(cnt_o), 32'h0000FFFF);
        end
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        beat_i = 1'b1; beat_chan = 2'd0;
        #1;
        chk("R1 masks", 32'(mask_o), 32'hF);
        chk("R1 tc status", 32'(tc_stat_o), 32'd0);
        chk("R1 done", 32'(done_o), 32'd0);
        chk("R1 no beat", 32'(beat_ok_o), 32'd0);
        beat_i = 1'b0;

        run_xfer(0, 16'h1230, 3, 8'h5A, 8'h44);

        // R9 masked channel ignores start
        @(negedge clk); start_i = 1'b1; start_chan = 2'd0;
        @(negedge clk); start_i = 1'b0; beat_i = 1'b1; beat_chan = 2'd0;
        #1 chk("R9 masked start ignored", 32'(beat_ok_o), 32'd0);
        @(negedge clk); beat_i = 1'b0;

        // R2 mode write lands on data channel, not wr_chan
        wr(SEL_MODE, 2'd0, 16'h0069);
        beat_chan = 2'd0; #1 chk("R2 ch0 mode untouched", 32'(dir_o), 32'd1);
        beat_chan = 2'd1; #1 chk("R2 ch1 mode written", 32'(dir_o), 32'd0);

        run_xfer(1, 16'h0001, 2, 8'h07, 8'h68);      // decrement wrap
        run_xfer(2, 16'hFFFE, 2, 8'hC3, 8'h54);      // auto-init, increment wrap
        run_xfer(3, 16'h8000, 1, 8'h22, 8'h78);      // auto-init, decrement

        // R11 mask set/clear by data channel
        wr(SEL_MASK, 2'd0, 16'h0005);
        #1 chk("R11 mask set", 32'(mask_o[1]), 32'd1);
        wr(SEL_MASK, 2'd3, 16'h0001);
        #1 chk("R11 mask clear", 32'(mask_o[1]), 32'd0);

        // R10 cascade forwarding
        wr(SEL_MODE, 2'd0, 16'h00C1);
        dreq_i = 4'b0011; ack_i = 4'b0011;
        #1;
        chk("R10 request forward", 32'(casc_req_o), 32'b0010);
        chk("R10 ack forward", 32'(casc_ack_o), 32'b0010);
        @(negedge clk); start_i = 1'b1; start_chan = 2'd1;
        @(negedge clk); start_i = 1'b0; beat_i = 1'b1; beat_chan = 2'd1;
        #1 chk("R10 no sequencing", 32'(beat_ok_o), 32'd0);
        @(negedge clk); beat_i = 1'b0; dreq_i = '0; ack_i = '0;

        // near-exhaustive sweep of short counts, both directions
        for (int c = 0; c <= 5; c++) begin
            for (int d = 0; d < 2; d++) begin
                run_xfer(0, 16'h4000 + 16'(c * 16), c, 8'h10 + 8'(c), (d != 0) ? 8'h68 : 8'h44);
            end
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule